// File: doc/BRIEF.md
# Bidirectional Digital Pin Expander Port

This block owns twelve general-purpose digital pins, numbered D0 to D11, and runs them from commands that a serial front-end has already shifted in and decoded into a 4-bit command code and a 12-bit data field. It keeps one direction bit and one output level bit per pin. On request it samples all twelve pin levels into a capture word. The front-end loads that word into its shift register, so it leaves the chip during the frame that follows the request.

The upper eight pins, D4 to D11, share their package pads with analog converter outputs. Pin D(12-k) pairs with converter channel A(4+k) for k = 1 to 8, so D11 pairs with A5 and D4 pairs with A12. The converter side reports a high-impedance flag for each of these channels. A shared pin whose direction bit asks for drive while its converter channel is still active raises a conflict flag, and its digital driver stays off. The safe way to hand a shared pad over is to put both sides in high impedance first. The serial shifting and the converter code registers are outside this block.

Top module: `gpio_expander_port`

## Requirements
- R1: After reset, pad_oe, pad_out, conflict and cap_word are all zero and cap_load is low.
- R2: A command with cmd_valid high and cmd_code 4'b1111 writes cmd_data into the direction bits. cmd_data bit i (frame bit S(4+i)) controls pin Di, and 1 means output while 0 means high-impedance input. The new directions show on pad_oe from the cycle after the command edge.
- R3: A command with cmd_valid high and cmd_code 4'b1101 writes cmd_data bit i into the output level of pin Di. pad_out shows the new levels from the cycle after the command edge, whatever the direction.
- R4: A command with cmd_valid high and cmd_code 4'b1110 samples pad_in at the command edge into cap_word, for every pin whatever its direction. cap_load is high for exactly the one following cycle, and cap_word holds its value until the next capture.
- R5: Any other code (4'b0000 to 4'b1100, including the converter-wide high-impedance command 4'b0000) leaves the direction bits, output levels and cap_word unchanged.
- R6: With cmd_valid low, nothing changes, whatever cmd_code and cmd_data carry.
- R7: conv_hiz bit j is the high-impedance flag of the converter channel paired with pin D(4+j), so bit 0 belongs to A12 and bit 7 to A5. conflict bit j is high exactly when the direction bit of D(4+j) is 1 and conv_hiz bit j is 0. It follows conv_hiz in the same cycle.
- R8: A shared pin with its conflict bit set has pad_oe low. Otherwise its pad_oe equals its direction bit.
- R9: Pins D0 to D3 are not affected by conv_hiz: their pad_oe always equals their direction bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Decoded frame strobe, one cycle per frame |
| cmd_code | input | 4 | Command code of the frame |
| cmd_data | input | 12 | Frame data field, bit i belongs to pin Di |
| conv_hiz | input | 8 | High-impedance flags of converter channels paired with D4..D11 |
| pad_in | input | 12 | Sensed pin levels |
| pad_oe | output | 12 | Per-pin driver enable |
| pad_out | output | 12 | Per-pin driven level |
| conflict | output | 8 | Shared-pad contention flags for D4..D11 |
| cap_word | output | 12 | Last sampled pin levels for the return frame |
| cap_load | output | 1 | One-cycle strobe telling the front-end to load cap_word |

## Verification
The properties assume that cmd_code and cmd_data mean something only in cycles where cmd_valid is high. They also assume that conv_hiz and pad_in are already synchronous to clk and settled at each rising edge. The bench changes every input only on the falling edge and drops cmd_valid after a single cycle. It changes conv_hiz only between commands, so every sampled value is unambiguous when a rising edge checks it.

// File: rtl/gpio_exp_pkg.sv
package gpio_exp_pkg;

  localparam int CODE_W = 4;

  localparam logic [CODE_W-1:0] CODE_SET_DIR  = 4'b1111;
  localparam logic [CODE_W-1:0] CODE_SET_OUT  = 4'b1101;
  localparam logic [CODE_W-1:0] CODE_CAPTURE  = 4'b1110;

  typedef struct packed {
    logic wr_dir;
    logic wr_out;
    logic capture;
  } gpio_cmd_t;

  // Turns a decoded frame into one-hot action strobes.
  function automatic gpio_cmd_t decode_cmd(input logic valid,
                                           input logic [CODE_W-1:0] code);
    gpio_cmd_t c;
    c.wr_dir  = valid && (code == CODE_SET_DIR);
    c.wr_out  = valid && (code == CODE_SET_OUT);
    c.capture = valid && (code == CODE_CAPTURE);
    return c;
  endfunction

  // A shared pad drives only when its converter channel has let go.
  function automatic logic shared_drive(input logic dir_bit, input logic hiz_bit);
    return dir_bit & hiz_bit;
  endfunction

  // Contention: digital side asks to drive while converter still drives.
  function automatic logic shared_clash(input logic dir_bit, input logic hiz_bit);
    return dir_bit & ~hiz_bit;
  endfunction

endpackage

// File: rtl/gpio_cmd_decode.sv
module gpio_cmd_decode
  import gpio_exp_pkg::*;
(
  input  logic              cmd_valid,
  input  logic [CODE_W-1:0] cmd_code,
  output gpio_cmd_t         cmd
);

  always_comb begin
    cmd = decode_cmd(cmd_valid, cmd_code);
  end

endmodule

// File: rtl/gpio_ctrl_reg.sv
module gpio_ctrl_reg #(
  parameter int          WIDTH   = 12,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= RST_VAL;
    end else if (wr_en) begin
      q <= wr_data;
    end
  end

endmodule

// File: rtl/gpio_share_guard.sv
module gpio_share_guard
  import gpio_exp_pkg::*;
#(
  parameter int NUM_PINS    = 12,
  parameter int SHARED_BASE = 4,
  localparam int NUM_SHARED = NUM_PINS - SHARED_BASE
) (
  input  logic [NUM_PINS-1:0]   dir_q,
  input  logic [NUM_SHARED-1:0] conv_hiz,
  output logic [NUM_PINS-1:0]   pad_oe,
  output logic [NUM_SHARED-1:0] conflict
);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    if (p < SHARED_BASE) begin : g_plain
      assign pad_oe[p] = dir_q[p];
    end else begin : g_shared
      assign pad_oe[p]                 = shared_drive(dir_q[p], conv_hiz[p-SHARED_BASE]);
      assign conflict[p-SHARED_BASE]   = shared_clash(dir_q[p], conv_hiz[p-SHARED_BASE]);
    end
  end

endmodule

// File: rtl/gpio_capture.sv
module gpio_capture #(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] cap_word,
  output logic             cap_load
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_word <= '0;
      cap_load <= 1'b0;
    end else begin
      cap_load <= cap_en;
      if (cap_en) begin
        cap_word <= pad_in;
      end
    end
  end

endmodule

// File: rtl/gpio_expander_port.sv
module gpio_expander_port
  import gpio_exp_pkg::*;
#(
  parameter int NUM_PINS    = 12,
  parameter int SHARED_BASE = 4,
  localparam int NUM_SHARED = NUM_PINS - SHARED_BASE
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  input  logic [CODE_W-1:0]     cmd_code,
  input  logic [NUM_PINS-1:0]   cmd_data,
  input  logic [NUM_SHARED-1:0] conv_hiz,
  input  logic [NUM_PINS-1:0]   pad_in,
  output logic [NUM_PINS-1:0]   pad_oe,
  output logic [NUM_PINS-1:0]   pad_out,
  output logic [NUM_SHARED-1:0] conflict,
  output logic [NUM_PINS-1:0]   cap_word,
  output logic                  cap_load
);

  gpio_cmd_t           cmd;
  logic [NUM_PINS-1:0] dir_q;

  gpio_cmd_decode u_dec (
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .cmd       (cmd)
  );

  gpio_ctrl_reg #(.WIDTH(NUM_PINS)) u_dir (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cmd.wr_dir),
    .wr_data (cmd_data),
    .q       (dir_q)
  );

  gpio_ctrl_reg #(.WIDTH(NUM_PINS)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cmd.wr_out),
    .wr_data (cmd_data),
    .q       (pad_out)
  );

  gpio_share_guard #(.NUM_PINS(NUM_PINS), .SHARED_BASE(SHARED_BASE)) u_guard (
    .dir_q    (dir_q),
    .conv_hiz (conv_hiz),
    .pad_oe   (pad_oe),
    .conflict (conflict)
  );

  gpio_capture #(.WIDTH(NUM_PINS)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (cmd.capture),
    .pad_in   (pad_in),
    .cap_word (cap_word),
    .cap_load (cap_load)
  );

endmodule

// File: rtl/gpio_expander_port_chk.sv
module gpio_expander_port_chk
  import gpio_exp_pkg::*;
#(
  parameter int NUM_PINS    = 12,
  parameter int SHARED_BASE = 4,
  localparam int NUM_SHARED = NUM_PINS - SHARED_BASE
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cmd_valid,
  input logic [CODE_W-1:0]     cmd_code,
  input logic [NUM_PINS-1:0]   cmd_data,
  input logic [NUM_SHARED-1:0] conv_hiz,
  input logic [NUM_PINS-1:0]   pad_in,
  input logic [NUM_PINS-1:0]   pad_oe,
  input logic [NUM_PINS-1:0]   pad_out,
  input logic [NUM_SHARED-1:0] conflict,
  input logic [NUM_PINS-1:0]   cap_word,
  input logic                  cap_load,
  input logic [NUM_PINS-1:0]   dir_q
);

  logic is_dir, is_out, is_cap;
  assign is_dir = cmd_valid && (cmd_code == CODE_SET_DIR);
  assign is_out = cmd_valid && (cmd_code == CODE_SET_OUT);
  assign is_cap = cmd_valid && (cmd_code == CODE_CAPTURE);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> (pad_oe == '0 || !rst_n));

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_dir |=> dir_q == $past(cmd_data));

  // R3
  out_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_out |=> pad_out == $past(cmd_data));

  // R4
  cap_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_cap |=> (cap_load && cap_word == $past(pad_in)));

  // R4
  cap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_cap |=> (!cap_load && $stable(cap_word)));

  // R5
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_dir |=> $stable(dir_q));

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_out |=> $stable(pad_out));

  // R7
  conflict_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conflict & conv_hiz) == '0);

  // R8
  conflict_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conflict & pad_oe[NUM_PINS-1:SHARED_BASE]) == '0);

  // R8
  clear_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conflict == '0) |-> pad_oe[NUM_PINS-1:SHARED_BASE] == dir_q[NUM_PINS-1:SHARED_BASE]);

  // R9
  plain_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe[SHARED_BASE-1:0] == dir_q[SHARED_BASE-1:0]);

endmodule

bind gpio_expander_port gpio_expander_port_chk #(
  .NUM_PINS    (NUM_PINS),
  .SHARED_BASE (SHARED_BASE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_code  (cmd_code),
  .cmd_data  (cmd_data),
  .conv_hiz  (conv_hiz),
  .pad_in    (pad_in),
  .pad_oe    (pad_oe),
  .pad_out   (pad_out),
  .conflict  (conflict),
  .cap_word  (cap_word),
  .cap_load  (cap_load),
  .dir_q     (dir_q)
);

// File: tb/gpio_expander_port_tb.sv
module gpio_expander_port_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd_code = '0;
  logic [11:0] cmd_data = '0;
  logic [7:0]  conv_hiz = 8'hFF;
  logic [11:0] pad_in = '0;
  logic [11:0] pad_oe, pad_out, cap_word;
  logic [7:0]  conflict;
  logic        cap_load;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // bench-side model of the per-pin state
  logic [11:0] m_dir = '0;
  logic [11:0] m_out = '0;
  logic [11:0] m_cap = '0;

  always #10 clk = ~clk;

  gpio_expander_port u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_data(cmd_data), .conv_hiz(conv_hiz), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .conflict(conflict),
    .cap_word(cap_word), .cap_load(cap_load)
  );

  function automatic logic [11:0] want_oe(logic [11:0] d, logic [7:0] h);
    logic [11:0] r;
    r = d;
    for (int j = 0; j < 8; j++) if (!h[j]) r[4+j] = 1'b0;
    return r;
  endfunction

  function automatic logic [7:0] want_clash(logic [11:0] d, logic [7:0] h);
    logic [7:0] r;
    for (int j = 0; j < 8; j++) r[j] = d[4+j] && !h[j];
    return r;
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic check_state(string req);
    check({req, " oe"},       32'(pad_oe),   32'(want_oe(m_dir, conv_hiz)));
    check({req, " out"},      32'(pad_out),  32'(m_out));
    check({req, " conflict"}, 32'(conflict), 32'(want_clash(m_dir, conv_hiz)));
    check({req, " cap"},      32'(cap_word), 32'(m_cap));
  endtask

  // one frame: drive at falling edge, result visible at the next falling edge
  task automatic send(logic [3:0] code, logic [11:0] data);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = code; cmd_data = data;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_code = 4'h0; cmd_data = '0;
  endtask

  task automatic t_reset;
    check_state("R1");
    check("R1 load", 32'(cap_load), 0);
  endtask

  task automatic t_dir_write;
    send(4'b1111, 12'hA5C); m_dir = 12'hA5C;
    check_state("R2");
    send(4'b1111, 12'h00F); m_dir = 12'h00F;
    check_state("R2 second");
  endtask

  task automatic t_out_write;
    send(4'b1101, 12'h3C9); m_out = 12'h3C9;
    check_state("R3");
    send(4'b1101, 12'hFFF); m_out = 12'hFFF;
    check_state("R3 all ones");
  endtask

  task automatic t_capture;
    pad_in = 12'h6B2;
    send(4'b1110, 12'h000); m_cap = 12'h6B2;
    check("R4 load", 32'(cap_load), 1);
    check_state("R4");
    pad_in = 12'h111;
    @(negedge clk);
    check("R4 pulse end", 32'(cap_load), 0);
    check("R4 hold", 32'(cap_word), 32'(m_cap));
    // an output pin reads back its own level
    send(4'b1101, 12'h0A0); m_out = 12'h0A0;
    send(4'b1111, 12'h0F0); m_dir = 12'h0F0;
    pad_in = (pad_out & pad_oe) | 12'h002;
    send(4'b1110, 12'hFFF); m_cap = 12'h0A2;
    check_state("R4 readback");
  endtask

  task automatic t_ignored;
    for (int c = 0; c <= 12; c++) begin
      pad_in = 12'hFFF;
      send(4'(c), 12'h5A5);
      check_state($sformatf("R5 code %0d", c));
      check("R5 load", 32'(cap_load), 0);
    end
  endtask

  task automatic t_no_valid;
    pad_in = 12'h777;
    @(negedge clk);
    cmd_code = 4'b1111; cmd_data = 12'hFFF;
    @(negedge clk);
    cmd_code = 4'b1110;
    @(negedge clk);
    cmd_code = 4'b1101; cmd_data = 12'h000;
    @(negedge clk);
    check_state("R6");
    check("R6 load", 32'(cap_load), 0);
    cmd_code = 4'h0; cmd_data = '0;
  endtask

  task automatic t_conflict;
    send(4'b1111, 12'hFFF); m_dir = 12'hFFF;
    conv_hiz = 8'b1010_0110;
    #1;
    check_state("R7 R8 mixed");
    check("R7 flags", 32'(conflict), 32'h59);
    check("R8 oe", 32'(pad_oe), 32'hA6F);
    conv_hiz = 8'h00;
    #1;
    check("R7 all clash", 32'(conflict), 32'hFF);
    check("R8 all off", 32'(pad_oe), 32'h00F);
    send(4'b1111, 12'h000); m_dir = 12'h000;
    check("R7 dir zero", 32'(conflict), 0);
    conv_hiz = 8'hFF;
    #1;
    check_state("R8 release");
  endtask

  task automatic t_plain_pins;
    send(4'b1111, 12'h00A); m_dir = 12'h00A;
    conv_hiz = 8'h00;
    #1;
    check("R9 low pins", 32'(pad_oe[3:0]), 32'hA);
    check("R9 no clash", 32'(conflict), 0);
    conv_hiz = 8'hFF;
    #1;
    check("R9 low pins hiz", 32'(pad_oe[3:0]), 32'hA);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_dir_write();
    t_out_write();
    t_capture();
    t_ignored();
    t_no_valid();
    t_conflict();
    t_plain_pins();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog got=hung exp=complete");
    finish_run();
  end

endmodule